// File: doc/BRIEF.md
# Clock Source Mode Controller

This block decides which of three oscillators drives the processor clock: a fast main crystal oscillator, an on-chip ring oscillator, or a slow subsystem oscillator. Software steers it through a small write port that holds a source-request register and an oscillator-halt register. The block turns those bits into a source-select code for an external glitch-free clock multiplexer, run enables for the main and ring oscillators, and two read-only status flags that name the active mode.

The controller allows only legal mode changes. The subsystem mode can be entered only from the main-oscillator mode and can only return to it. A move to a source that is halted or not yet ready waits until that source reports ready. Two halt bits can stop the main oscillator, and the mode decides which one counts. The oscillator that is currently clocking the processor is never stopped. A strap input decides whether software may halt the ring oscillator at all.

The oscillators and the clock multiplexer lie outside this block. Each oscillator is seen only through its enable output and its ready input.

Top module: `clksrc_mode_ctrl`

## Requirements
- R1: After reset, `clk_sel` is 2'b00 (ring), both status flags are 0, and `main_osc_en` and `ring_osc_en` are 1. All control bits are cleared.
- R2: The `clk_sel` encoding is ring 2'b00, main 2'b01, subsystem 2'b10. `stat_sub` is 1 only in subsystem mode. `stat_main` is 1 in main and subsystem modes and 0 in ring mode. The flags change in the same cycle as `clk_sel`.
- R3: In main mode, `main_osc_en` stays 1 whatever the halt bits hold.
- R4: In ring mode, `main_osc_en` equals the inverse of the direct halt bit (address 1, bit 0). The subsystem-path halt bit has no effect.
- R5: In subsystem mode, `main_osc_en` equals the inverse of the subsystem-path halt bit (address 1, bit 1). The direct halt bit has no effect.
- R6: Subsystem mode is entered only from main mode and is left only toward main mode. A subsystem request (address 0, bit 0) made in ring mode is ignored.
- R7: In subsystem mode, clearing the main-select bit (address 0, bit 1) has no effect while the subsystem request stays set.
- R8: The ring halt bit (address 1, bit 2) drops `ring_osc_en` only when `ring_sw_stop_ok` is 1 and the mode is not ring. In every other case `ring_osc_en` stays 1.
- R9: A mode change happens at the first clock edge at which the request is registered and the target source is ready (`main_rdy` with `main_osc_en`, `ring_rdy` with `ring_osc_en`, or `sub_rdy`). Until then the current mode is held.
- R10: Writes to address 2 (the status location) and to address 3 change no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 source request, 1 oscillator halt, 2 status (read-only) |
| wr_data | input | 3 | Write data |
| ring_sw_stop_ok | input | 1 | Strap: software may halt the ring oscillator |
| main_rdy | input | 1 | Main oscillator output is stable |
| ring_rdy | input | 1 | Ring oscillator output is stable |
| sub_rdy | input | 1 | Subsystem oscillator output is stable |
| main_osc_en | output | 1 | Run enable for the main oscillator |
| ring_osc_en | output | 1 | Run enable for the ring oscillator |
| clk_sel | output | 2 | Source-select code for the clock multiplexer |
| stat_sub | output | 1 | Status: subsystem mode active |
| stat_main | output | 1 | Status: main or subsystem mode active |

## Verification
A corrupt mode register shows on `clk_sel` and on both status flags in the same cycle. It also shows on the enables, because the halt bit that counts depends on the mode. A wrong halt-gating term shows as soon as the halt register is written, one edge after the write strobe. A mode change that skipped the ready check shows as a `clk_sel` change one edge too early, or in a mode from which that change is not allowed. The bench sweeps every halt and strap combination in every mode and compares all outputs against an arithmetic model at each step.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 3;

  localparam logic [ADDR_W-1:0] A_SRC  = 2'd0;
  localparam logic [ADDR_W-1:0] A_HALT = 2'd1;

  localparam int B_SUB_REQ  = 0;
  localparam int B_MAIN_SEL = 1;
  localparam int B_HALT_DIR = 0;
  localparam int B_HALT_SUB = 1;
  localparam int B_HALT_RNG = 2;

  typedef enum logic [1:0] {
    SRC_RING = 2'b00,
    SRC_MAIN = 2'b01,
    SRC_SUB  = 2'b10
  } src_e;

  typedef struct packed {
    logic sub_req;
    logic main_sel;
    logic halt_dir;
    logic halt_sub;
    logic halt_rng;
  } ctrl_t;
endpackage

// File: rtl/csm_ctrl_regs.sv
module csm_ctrl_regs
  import clksrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  output ctrl_t             ctrl_q
);
  ctrl_t ctrl_d;
  logic  src_we;
  logic  halt_we;

  assign src_we  = wr_en && (wr_addr == A_SRC);
  assign halt_we = wr_en && (wr_addr == A_HALT);

  always_comb begin
    ctrl_d = ctrl_q;
    if (src_we) begin
      ctrl_d.sub_req  = wr_data[B_SUB_REQ];
      ctrl_d.main_sel = wr_data[B_MAIN_SEL];
    end
    if (halt_we) begin
      ctrl_d.halt_dir = wr_data[B_HALT_DIR];
      ctrl_d.halt_sub = wr_data[B_HALT_SUB];
      ctrl_d.halt_rng = wr_data[B_HALT_RNG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (src_we || halt_we) begin
      ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/csm_osc_gate.sv
module csm_osc_gate
  import clksrc_pkg::*;
(
  input  src_e  mode_q,
  input  ctrl_t ctrl_q,
  input  logic  ring_sw_stop_ok,
  output logic  main_osc_en,
  output logic  ring_osc_en
);
  always_comb begin
    unique case (mode_q)
      SRC_MAIN: main_osc_en = 1'b1;
      SRC_SUB:  main_osc_en = !ctrl_q.halt_sub;
      default:  main_osc_en = !ctrl_q.halt_dir;
    endcase
  end

  always_comb begin
    if (mode_q == SRC_RING) begin
      ring_osc_en = 1'b1;
    end else begin
      ring_osc_en = !(ctrl_q.halt_rng && ring_sw_stop_ok);
    end
  end
endmodule

// File: rtl/csm_mode_fsm.sv
module csm_mode_fsm
  import clksrc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl_q,
  input  logic  main_ok,
  input  logic  ring_ok,
  input  logic  sub_ok,
  output src_e  mode_q
);
  src_e mode_d;
  logic mode_ce;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      SRC_RING: begin
        if (ctrl_q.main_sel && main_ok) mode_d = SRC_MAIN;
      end
      SRC_MAIN: begin
        if (ctrl_q.sub_req) begin
          if (sub_ok) mode_d = SRC_SUB;
        end else if (!ctrl_q.main_sel && ring_ok) begin
          mode_d = SRC_RING;
        end
      end
      SRC_SUB: begin
        if (!ctrl_q.sub_req && main_ok) mode_d = SRC_MAIN;
      end
      default: mode_d = SRC_RING;
    endcase
  end

  assign mode_ce = (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SRC_RING;
    end else if (mode_ce) begin
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/clksrc_mode_ctrl.sv
module clksrc_mode_ctrl
  import clksrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              ring_sw_stop_ok,
  input  logic              main_rdy,
  input  logic              ring_rdy,
  input  logic              sub_rdy,
  output logic              main_osc_en,
  output logic              ring_osc_en,
  output logic [1:0]        clk_sel,
  output logic              stat_sub,
  output logic              stat_main
);
  ctrl_t ctrl_q;
  src_e  mode_q;

  csm_ctrl_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q)
  );

  csm_osc_gate u_gate (
    .mode_q          (mode_q),
    .ctrl_q          (ctrl_q),
    .ring_sw_stop_ok (ring_sw_stop_ok),
    .main_osc_en     (main_osc_en),
    .ring_osc_en     (ring_osc_en)
  );

  csm_mode_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_q  (ctrl_q),
    .main_ok (main_rdy && main_osc_en),
    .ring_ok (ring_rdy && ring_osc_en),
    .sub_ok  (sub_rdy),
    .mode_q  (mode_q)
  );

  assign clk_sel   = mode_q;
  assign stat_sub  = (mode_q == SRC_SUB);
  assign stat_main = (mode_q == SRC_SUB) || (mode_q == SRC_MAIN);
endmodule

// File: rtl/clksrc_mode_ctrl_chk.sv
module clksrc_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ring_sw_stop_ok,
  input logic       main_rdy,
  input logic       sub_rdy,
  input logic       main_osc_en,
  input logic       ring_osc_en,
  input logic [1:0] clk_sel,
  input logic       stat_sub,
  input logic       stat_main
);
  logic [1:0] prev_sel;
  logic       prev_main_ok;
  logic       prev_sub_ok;
  logic       hist_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel     <= 2'b00;
      prev_main_ok <= 1'b0;
      prev_sub_ok  <= 1'b0;
      hist_ok      <= 1'b0;
    end else begin
      prev_sel     <= clk_sel;
      prev_main_ok <= main_rdy && main_osc_en;
      prev_sub_ok  <= sub_rdy;
      hist_ok      <= 1'b1;
    end
  end

  p_sel_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel != 2'b11);
  p_stat_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sub == (clk_sel == 2'b10));
  p_stat_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_main == (clk_sel != 2'b00));
  p_main_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b01) |-> main_osc_en);
  p_ring_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'b00) |-> ring_osc_en);
  p_ring_strap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_sw_stop_ok |-> ring_osc_en);
  p_sub_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && clk_sel == 2'b10 && prev_sel != 2'b10) |-> (prev_sel == 2'b01));
  p_sub_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && prev_sel == 2'b10 && clk_sel != 2'b10) |-> (clk_sel == 2'b01));
  p_main_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && clk_sel == 2'b01 && prev_sel != 2'b01) |-> prev_main_ok);
  p_sub_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hist_ok && clk_sel == 2'b10 && prev_sel != 2'b10) |-> prev_sub_ok);
endmodule

bind clksrc_mode_ctrl clksrc_mode_ctrl_chk chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .ring_sw_stop_ok (ring_sw_stop_ok),
  .main_rdy        (main_rdy),
  .sub_rdy         (sub_rdy),
  .main_osc_en     (main_osc_en),
  .ring_osc_en     (ring_osc_en),
  .clk_sel         (clk_sel),
  .stat_sub        (stat_sub),
  .stat_main       (stat_main)
);

// File: tb/clksrc_mode_ctrl_tb_top.sv
module clksrc_mode_ctrl_tb_top;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [2:0] wr_data;
  logic       ring_sw_stop_ok;
  logic       main_rdy, ring_rdy, sub_rdy;
  logic       main_osc_en, ring_osc_en;
  logic [1:0] clk_sel;
  logic       stat_sub, stat_main;

  int n_chk;
  int n_bad;
  bit done;
  // bench model of the halt bits and strap
  bit m_hd, m_hs, m_rh, m_opt;

  clksrc_mode_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ring_sw_stop_ok(ring_sw_stop_ok), .main_rdy(main_rdy), .ring_rdy(ring_rdy),
    .sub_rdy(sub_rdy), .main_osc_en(main_osc_en), .ring_osc_en(ring_osc_en),
    .clk_sel(clk_sel), .stat_sub(stat_sub), .stat_main(stat_main)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // mode: 0 ring, 1 main, 2 sub
  function automatic logic [5:0] expect_vec(input int mode);
    logic [1:0] sel;
    logic ss, sm, me, re;
    sel = 2'(mode);
    ss  = (mode == 2);
    sm  = (mode != 0);
    me  = (mode == 1) ? 1'b1 : (mode == 0) ? !m_hd : !m_hs;
    re  = (mode == 0) ? 1'b1 : !(m_rh && m_opt);
    return {sel, ss, sm, me, re};
  endfunction

  task automatic check(input string req, input int mode);
    logic [5:0] act, exp;
    act = {clk_sel, stat_sub, stat_main, main_osc_en, ring_osc_en};
    exp = expect_vec(mode);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {sel,ssub,smain,men,ren} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_halt(input bit hd, input bit hs, input bit rh);
    m_hd = hd; m_hs = hs; m_rh = rh;
    wr(2'd1, {rh, hs, hd});
  endtask

  task automatic sweep(input string req, input int mode);
    for (int i = 0; i < 16; i++) begin
      m_opt = i[3];
      ring_sw_stop_ok = m_opt;
      set_halt(i[0], i[1], i[2]);
      check(req, mode);
      step();
      check(req, mode);
    end
    set_halt(0, 0, 0);
    m_opt = 0; ring_sw_stop_ok = 0;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    m_hd = 0; m_hs = 0; m_rh = 0; m_opt = 0;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    ring_sw_stop_ok = 0; main_rdy = 1; ring_rdy = 1; sub_rdy = 1;
    repeat (3) step();
    rst_n = 1;
    step();
    check("R1 reset state", 0);
    check("R2 ring encoding", 0);

    sweep("R4/R8 ring mode halt sweep", 0);

    // R9: main not ready -> request pending
    main_rdy = 0;
    wr(2'd0, 3'b010);
    repeat (3) begin step(); check("R9 pending on main_rdy", 0); end
    main_rdy = 1;
    step();
    check("R9 switch to main after ready", 1);
    check("R2 main encoding", 1);

    sweep("R3/R8 main mode halt sweep", 1);

    // back to ring, then R9 pending on halted main
    wr(2'd0, 3'b000);
    step();
    check("R9 return to ring", 0);
    set_halt(1, 0, 0);
    wr(2'd0, 3'b010);
    repeat (3) begin step(); check("R9 pending on halted main", 0); end
    set_halt(0, 0, 0);
    step();
    check("R9 switch after main halt cleared", 1);

    // R6: subsystem request from ring ignored
    wr(2'd0, 3'b000);
    step();
    check("R6 ring before sub request", 0);
    wr(2'd0, 3'b001);
    repeat (3) begin step(); check("R6 sub request ignored in ring", 0); end

    // to main, then pending sub entry
    wr(2'd0, 3'b010);
    step();
    check("R6 main before sub entry", 1);
    sub_rdy = 0;
    wr(2'd0, 3'b011);
    repeat (2) begin step(); check("R9 pending on sub_rdy", 1); end
    sub_rdy = 1;
    step();
    check("R6 sub entered from main", 2);
    check("R2 sub encoding", 2);

    sweep("R5/R8 sub mode halt sweep", 2);

    // R7: clearing main select ignored in sub
    wr(2'd0, 3'b001);
    repeat (3) begin step(); check("R7 main_sel clear ignored", 2); end

    // R10: status and unused addresses discarded
    wr(2'd2, 3'b000);
    step();
    check("R10 status write discarded", 2);
    wr(2'd3, 3'b000);
    step();
    check("R10 addr 3 write discarded", 2);

    // exit toward main held while main halted through subsystem path
    set_halt(0, 1, 0);
    wr(2'd0, 3'b010);
    repeat (2) begin step(); check("R9 sub exit pending on halted main", 2); end
    set_halt(0, 0, 0);
    step();
    check("R6 sub exits to main", 1);

    wr(2'd2, 3'b111);
    step();
    check("R10 status write in main", 1);

    // R1 again after a second reset
    rst_n = 0;
    step();
    m_hd = 0; m_hs = 0; m_rh = 0;
    rst_n = 1;
    step();
    check("R1 reset from main", 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=completed");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule